// File: doc/BRIEF.md
# Single-Cycle Execution Datapath

This block is the execution half of a small single-cycle processor core. It holds a sixteen-entry, 32-bit register file, a two-bit-coded arithmetic unit, a 64-word data store, a sign extender for an 8-bit immediate, and two selectors. One selector picks the arithmetic unit's second operand. The other picks what is written back to the register file. Every control line is a top-level input, driven each cycle by an external decoder: the read and write register numbers, the register write enable, the operation code, the operand select, the write-back select and the store enable. Instruction fetch, the program counter and branching live elsewhere.

A single clock cycle carries out one of six kinds of operation:
- register-register add or subtract;
- register-plus-immediate add or subtract;
- a load;
- a store.

Arithmetic results can go back to a register, or serve as the store address so that a register value is written to memory. The low six bits of the arithmetic result address the data store directly. The data written to the store always comes from the second register read port. The full arithmetic result and its sign bit are brought out, so a neighbouring unit can steer control flow from them.

The reset input is active low and asynchronous, and clears the register file and the data store. Its release is synchronised internally by two flip-flop stages.

Top module: `pu_datapath`

## Requirements
- R1: While reset is applied, and after it is released, every register and every data-store word reads as zero until it is written.
- R2: A register is written with the write-back value on a rising clock edge only when `reg_wr_en` is 1, at index `wr_addr`. With `reg_wr_en` at 0, no register changes.
- R3: `alu_op` is decoded as follows: 2'b00 gives A+B, 2'b01 passes B, 2'b10 gives A−B and 2'b11 passes A. A is read port A, and B is the selected second operand.
- R4: Addition and subtraction wrap modulo 2^32.
- R5: `neg_flag` equals bit 31 of `alu_res` in every cycle.
- R6: When `opnd_sel` is 0, operand B is register read port B. When it is 1, operand B is the sign-extended immediate.
- R7: Sign extension copies bit 7 of `imm` into bits 31 to 8.
- R8: On a rising edge with `mem_wr_en` at 1, the data store writes read port B into the word addressed by `alu_res[5:0]`. Bits 31 to 6 of `alu_res` are ignored. With `mem_wr_en` at 0, no word changes.
- R9: When `wb_sel` is 0, the write-back value is the ALU result. When it is 1, the write-back value is the data-store word addressed by `alu_res[5:0]`, read combinationally.
- R10: Register reads are combinational. A value written on an edge is visible on the read ports in the cycle after that edge.
- R11: After `rst_n` rises, the first two rising clock edges still hold the state in reset. The third edge is the first to commit a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 4 | Register index for read port A |
| rd_addr_b | input | 4 | Register index for read port B |
| wr_addr | input | 4 | Register index for the write port |
| reg_wr_en | input | 1 | Register write enable |
| alu_op | input | 2 | ALU operation code |
| opnd_sel | input | 1 | Second-operand select: 0 = port B, 1 = immediate |
| imm | input | 8 | Signed immediate |
| wb_sel | input | 1 | Write-back select: 0 = ALU result, 1 = data-store word |
| mem_wr_en | input | 1 | Data-store write enable |
| alu_res | output | 32 | ALU result, which is also the store address source |
| neg_flag | output | 1 | Sign bit of the ALU result |

## Verification
The data store has no port of its own. Its contents only become visible after a load copies a word into a register and a pass-A operation then puts that register on `alu_res`. The bench therefore builds three-step chains of store, load and read. One store computes an address whose upper bits are set, so that it lands on a low word, which shows that the address is truncated to six bits. A disabled store followed by the same chain shows that the word kept its cleared value. The synchronised reset release is reached by holding an incrementing write active across the release, and then watching on which edge the register first changes.

// File: rtl/pu_pkg.sv
package pu_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned MEM_WORDS = 64;
  localparam int unsigned IMM_W    = 8;

  typedef enum logic [1:0] {
    ALU_ADD    = 2'b00,
    ALU_PASS_B = 2'b01,
    ALU_SUB    = 2'b10,
    ALU_PASS_A = 2'b11
  } alu_op_e;
endpackage

// File: rtl/pu_rst_sync.sv
module pu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  // R11: the internal reset only deasserts after the external one was high
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n));
endmodule

// File: rtl/pu_regfile.sv
module pu_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] regs_q [NREG];
  logic [NREG-1:0] load;

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    assign load[i] = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regs_q[i] <= '0;
      else if (load[i]) regs_q[i] <= wr_data;
    end

    // R2: an enabled write lands in the addressed entry
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      load[i] |=> regs_q[i] == $past(wr_data));
    // R2: entries not addressed by an enabled write keep their value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load[i] |=> $stable(regs_q[i]));
  end

  assign rd_data_a = regs_q[rd_addr_a];
  assign rd_data_b = regs_q[rd_addr_b];
endmodule

// File: rtl/pu_datamem.sv
module pu_datamem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 32,
  localparam int unsigned MAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MAW-1:0] addr,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   rd_data
);
  logic [W-1:0] words_q [DEPTH];
  logic [DEPTH-1:0] store;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign store[i] = wr_en && (addr == MAW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words_q[i] <= '0;
      else if (store[i]) words_q[i] <= wr_data;
    end

    // R8: a store writes the addressed word
    a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
      store[i] |=> words_q[i] == $past(wr_data));
    // R8: other words are untouched
    a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !store[i] |=> $stable(words_q[i]));
  end

  assign rd_data = words_q[addr];
endmodule

// File: rtl/pu_alu.sv
module pu_alu
  import pu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         neg
);
  always_comb begin
    unique case (op)
      ALU_ADD:    res = opa + opb;
      ALU_PASS_B: res = opb;
      ALU_SUB:    res = opa - opb;
      ALU_PASS_A: res = opa;
      default:    res = opa;
    endcase
  end

  assign neg = res[W-1];

  // R3/R4: sums and differences are consistent under wrap-around
  always_comb begin
    if (op == ALU_ADD) begin
      a_r3_add_inverse: assert (res - opb == opa);
    end
    if (op == ALU_SUB) begin
      a_r4_sub_inverse: assert (res + opb == opa);
    end
  end
endmodule

// File: rtl/pu_sext.sv
module pu_sext #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned EXT_W = OUT_W - IN_W;
  assign dout = {{EXT_W{din[IN_W-1]}}, din};
endmodule

// File: rtl/pu_datapath.sv
module pu_datapath
  import pu_pkg::*;
#(
  parameter int unsigned W         = DATA_W,
  parameter int unsigned NREG      = NUM_REGS,
  parameter int unsigned DEPTH     = MEM_WORDS,
  parameter int unsigned IW        = IMM_W,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned AW       = $clog2(NREG),
  localparam int unsigned MAW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [AW-1:0] wr_addr,
  input  logic          reg_wr_en,
  input  logic [1:0]    alu_op,
  input  logic          opnd_sel,
  input  logic [IW-1:0] imm,
  input  logic          wb_sel,
  input  logic          mem_wr_en,
  output logic [W-1:0]  alu_res,
  output logic          neg_flag
);
  logic         rst_int_n;
  logic [W-1:0] port_a, port_b, imm_ext, opnd_b, mem_rd, wb_data;

  pu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  pu_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk(clk), .rst_n(rst_int_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(port_a), .rd_data_b(port_b),
    .wr_en(reg_wr_en), .wr_addr(wr_addr), .wr_data(wb_data)
  );

  pu_sext #(.IN_W(IW), .OUT_W(W)) u_sext (.din(imm), .dout(imm_ext));

  assign opnd_b = opnd_sel ? imm_ext : port_b;

  pu_alu #(.W(W)) u_alu (
    .opa(port_a), .opb(opnd_b), .op(alu_op_e'(alu_op)),
    .res(alu_res), .neg(neg_flag)
  );

  pu_datamem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk(clk), .rst_n(rst_int_n),
    .addr(alu_res[MAW-1:0]), .wr_en(mem_wr_en),
    .wr_data(port_b), .rd_data(mem_rd)
  );

  assign wb_data = wb_sel ? mem_rd : alu_res;

  // R9: a load writes back the word the store would have addressed
  a_r9_load_path: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr_en && wb_sel && !mem_wr_en) |=> u_rf.regs_q[$past(wr_addr)] == $past(mem_rd));
endmodule

// File: tb/pu_datapath_tb_top.sv
module pu_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic        reg_wr_en, opnd_sel, wb_sel, mem_wr_en;
  logic [1:0]  alu_op;
  logic [7:0]  imm;
  logic [31:0] alu_res;
  logic        neg_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pu_datapath dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
    .reg_wr_en(reg_wr_en), .alu_op(alu_op), .opnd_sel(opnd_sel),
    .imm(imm), .wb_sel(wb_sel), .mem_wr_en(mem_wr_en),
    .alu_res(alu_res), .neg_flag(neg_flag)
  );

  typedef struct packed {
    logic [3:0]  ra, rb, rw;
    logic        we;
    logic [1:0]  op;
    logic        sel;
    logic [7:0]  im;
    logic        wb, mw;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 4'd0, 4'd1,  1'b1, 2'b01, 1'b1, 8'h05, 1'b0, 1'b0, 32'h0000_0005, 8'd7},  // R7 r1=5
    '{4'd0, 4'd0, 4'd2,  1'b1, 2'b01, 1'b1, 8'hFE, 1'b0, 1'b0, 32'hFFFF_FFFE, 8'd7},  // R7 r2=-2
    '{4'd1, 4'd2, 4'd3,  1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0003, 8'd4},  // R4 wrap add
    '{4'd1, 4'd2, 4'd4,  1'b1, 2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0007, 8'd3},  // R3 sub
    '{4'd0, 4'd1, 4'd5,  1'b1, 2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 32'hFFFF_FFFB, 8'd5},  // R5 negative
    '{4'd3, 4'd0, 4'd1,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0003, 8'd10}, // R10 read r3
    '{4'd1, 4'd0, 4'd0,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0005, 8'd2},  // R2 r1 held
    '{4'd1, 4'd4, 4'd0,  1'b0, 2'b00, 1'b1, 8'h03, 1'b0, 1'b1, 32'h0000_0008, 8'd8},  // R8 store mem[8]=7
    '{4'd0, 4'd0, 4'd6,  1'b1, 2'b00, 1'b1, 8'h08, 1'b1, 1'b0, 32'h0000_0008, 8'd9},  // R9 load r6
    '{4'd6, 4'd0, 4'd0,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0007, 8'd9},  // R9 r6=7
    '{4'd5, 4'd3, 4'd0,  1'b0, 2'b00, 1'b1, 8'h4A, 1'b0, 1'b1, 32'h0000_0045, 8'd8},  // R8 addr trunc -> 5
    '{4'd0, 4'd0, 4'd7,  1'b1, 2'b00, 1'b1, 8'h05, 1'b1, 1'b0, 32'h0000_0005, 8'd8},  // R8 load mem[5]
    '{4'd7, 4'd0, 4'd0,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0003, 8'd8},  // R8 r7=3
    '{4'd1, 4'd0, 4'd8,  1'b1, 2'b00, 1'b1, 8'h80, 1'b0, 1'b0, 32'hFFFF_FF85, 8'd7},  // R7 imm -128
    '{4'd8, 4'd0, 4'd0,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'hFFFF_FF85, 8'd5},  // R5 r8
    '{4'd0, 4'd0, 4'd1,  1'b0, 2'b01, 1'b1, 8'h7F, 1'b0, 1'b0, 32'h0000_007F, 8'd6},  // R6 imm, no write
    '{4'd1, 4'd0, 4'd0,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0005, 8'd2},  // R2 r1 still 5
    '{4'd0, 4'd4, 4'd0,  1'b0, 2'b00, 1'b1, 8'h09, 1'b0, 1'b0, 32'h0000_0009, 8'd8},  // R8 store disabled
    '{4'd0, 4'd0, 4'd9,  1'b1, 2'b00, 1'b1, 8'h09, 1'b1, 1'b0, 32'h0000_0009, 8'd8},  // R8 load mem[9]
    '{4'd9, 4'd0, 4'd0,  1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0000, 8'd8},  // R8 mem[9]=0
    '{4'd2, 4'd2, 4'd10, 1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 32'hFFFF_FFFC, 8'd4},  // R4 r10
    '{4'd0, 4'd4, 4'd0,  1'b0, 2'b01, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0000_0007, 8'd6},  // R6 port B
    '{4'd10, 4'd0, 4'd0, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 32'hFFFF_FFFC, 8'd4}   // R4 r10 read
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ra, input logic [3:0] rb, input logic [3:0] rw,
                       input logic we, input logic [1:0] op, input logic sel,
                       input logic [7:0] im, input logic wb, input logic mw);
    rd_addr_a = ra; rd_addr_b = rb; wr_addr = rw; reg_wr_en = we;
    alu_op = op; opnd_sel = sel; imm = im; wb_sel = wb; mem_wr_en = mw;
  endtask

  initial begin
    rst_n = 1'b1;
    drive(4'd4, 4'd0, 4'd0, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #9;
    check(alu_res, 32'h0, "R1 reset read r4");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k].ra, VEC[k].rb, VEC[k].rw, VEC[k].we, VEC[k].op,
            VEC[k].sel, VEC[k].im, VEC[k].wb, VEC[k].mw);
      #1;
      check(alu_res, VEC[k].exp, $sformatf("R%0d vector %0d result", VEC[k].req, k));
      check({31'b0, neg_flag}, {31'b0, VEC[k].exp[31]}, $sformatf("R5 vector %0d neg", k));
    end

    // R1: reset in the middle of a run clears registers asynchronously
    @(negedge clk);
    drive(4'd1, 4'd0, 4'd0, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check(alu_res, 32'h0, "R1 r1 cleared during reset");

    // R11: increment r1 across the release, first two edges ignored
    @(negedge clk);
    drive(4'd1, 4'd0, 4'd1, 1'b1, 2'b00, 1'b1, 8'h01, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(alu_res, 32'h1, "R11 edge 1 held in reset");
    @(negedge clk); #1;
    check(alu_res, 32'h1, "R11 edge 2 held in reset");
    @(negedge clk); #1;
    check(alu_res, 32'h2, "R11 edge 3 commits");

    // R1: data-store word 8 was cleared by the reset
    @(negedge clk);
    drive(4'd0, 4'd0, 4'd12, 1'b1, 2'b00, 1'b1, 8'h08, 1'b1, 1'b0);
    @(negedge clk);
    drive(4'd12, 4'd0, 4'd0, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0);
    #1;
    check(alu_res, 32'h0, "R1 mem[8] cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule